// File: doc/BRIEF.md
# Dual-Bank Byte-Addressed GPIO Controller

This block is a byte-wide register file that owns a set of general-purpose pins split into two banks: a core bank and a resume bank. Each bank has its own active-low reset, so one bank can be cleared while the other keeps its state. Software reaches the pins through an 8-bit port-style bus. A read returns data in the same cycle as the strobe, and a write lands on the clock edge that samples the strobe.

Each pin has three control bits: an enable bit, a direction bit and a level bit. The block turns them into an output value and an output enable for a tri-state pad. Pad inputs pass through a two-flop synchronizer before the level register reports them. Software changes single bits by reading a whole byte, modifying it and writing it back. For that to work, every byte reads back exactly what was last written to its enable and direction bits.

Top module: `dualbank_gpio_ctrl`

## Requirements
- R1: Address map. Bit 5 of the address picks the bank: 0 is the core bank and 1 is the resume bank. Address bits [4:2] pick the register set: 0 is enable, 1 is direction and 2 is level. Address bits [1:0] pick the byte. Pin k of a bank sits in byte k/8, at bit k%8. Resume pins are numbered from 0 within their bank and appear at pad index CORE_PINS+k.
- R2: At reset, the enable bit is 1 for the lowest CORE_ON_AT_RESET core pins and the lowest RESUME_ON_AT_RESET resume pins, and 0 for all other pins. All direction bits reset to 1 and all level bits reset to 0.
- R3: Enable and direction bits read back exactly the value last written to them. A write takes effect on the clock edge that samples bus_wr high. A read is combinational while bus_rd is high.
- R4: A direction bit of 1 makes the pin an input, with pad_oe at 0. An enabled pin with direction 0 drives pad_oe to 1, and pad_out equals its stored level bit.
- R5: A write to a level bit is ignored while that pin's direction bit is 1.
- R6: When a pin is switched to output, the pad drives the stored level bit until software writes a new level.
- R7: Reading the level of an enabled input pin returns the synchronized pad value. A pad change made before clock edge k becomes visible after edge k+1. Reading the level of an enabled output pin returns the stored level.
- R8: A pin whose enable bit is 0 has pad_oe at 0, and its level read returns 0.
- R9: Some reads return 0: bit positions with no pin, register-set codes 3 to 7, and any read while bus_rd is low. Writes to bit positions with no pin and to register-set codes 3 to 7 change no state.
- R10: Each bank's registers are cleared only by that bank's own reset input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| core_rst_n | input | 1 | Active-low reset of the core bank |
| resume_rst_n | input | 1 | Active-low reset of the resume bank |
| bus_addr | input | 6 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the same cycle as bus_rd |
| pad_in | input | CORE_PINS+RESUME_PINS | Pad input values |
| pad_out | output | CORE_PINS+RESUME_PINS | Pad output values |
| pad_oe | output | CORE_PINS+RESUME_PINS | Pad output enables |

## Verification
Register writes, pad_out and pad_oe change on the edge that samples bus_wr. The bench drives each write at a falling edge and checks the pads and the read-back from the next falling edge onward. Read data is combinational, so each read is checked 1 ns after the strobe is raised, within the same cycle. A pad change reaches the level read two edges later. The bench drives each pad pattern and then waits two rising edges before any level read depends on it. One directed case samples before and after that second edge to pin down the latency.

// File: rtl/dbgpio_pkg.sv
package dbgpio_pkg;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 8;
  localparam int SET_W      = 3;
  localparam int BYTE_SEL_W = 2;
  localparam int MAX_BANK_PINS = DATA_W * (1 << BYTE_SEL_W);

  typedef enum logic [SET_W-1:0] {
    SET_ENABLE = 3'd0,
    SET_DIR    = 3'd1,
    SET_LEVEL  = 3'd2
  } reg_set_e;

  function automatic logic bank_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1];
  endfunction

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[BYTE_SEL_W +: SET_W];
  endfunction

  function automatic logic [BYTE_SEL_W-1:0] byte_of(input logic [ADDR_W-1:0] a);
    return a[BYTE_SEL_W-1:0];
  endfunction

  function automatic int pin_byte(input int idx);
    return idx / DATA_W;
  endfunction

  function automatic int pin_bit(input int idx);
    return idx % DATA_W;
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import dbgpio_pkg::*;
#(
  parameter int PINS     = 10,
  parameter int RESET_ON = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [SET_W-1:0]      set_sel,
  input  logic [BYTE_SEL_W-1:0] byte_sel,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [PINS-1:0]       pad_in,
  output logic [PINS-1:0]       pad_out,
  output logic [PINS-1:0]       pad_oe,
  output logic [DATA_W-1:0]     rdata
);
  logic [PINS-1:0] en_q, dir_q, lvl_q, pad_s;
  logic [PINS-1:0] byte_hit;
  logic [PINS-1:0] lvl_view;
  logic            wr_en_set, wr_dir_set, wr_lvl_set;
  logic [PINS-1:0] lvl_wr_blocked;
  logic [PINS-1:0] lvl_wr_taken;

  gpio_sync2 #(.W(PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (pad_s)
  );

  assign wr_en_set  = wr && (set_sel == SET_ENABLE);
  assign wr_dir_set = wr && (set_sel == SET_DIR);
  assign wr_lvl_set = wr && (set_sel == SET_LEVEL);

  always_comb begin
    for (int i = 0; i < PINS; i++) begin
      byte_hit[i] = (pin_byte(i) == int'(byte_sel));
    end
  end

  assign lvl_wr_blocked = {PINS{wr_lvl_set}} & byte_hit & dir_q;
  assign lvl_wr_taken   = {PINS{wr_lvl_set}} & byte_hit & ~dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PINS; i++) begin
        en_q[i] <= (i < RESET_ON);
      end
      dir_q <= '1;
      lvl_q <= '0;
    end else begin
      for (int i = 0; i < PINS; i++) begin
        if (wr_en_set && byte_hit[i])  en_q[i]  <= wdata[pin_bit(i)];
        if (wr_dir_set && byte_hit[i]) dir_q[i] <= wdata[pin_bit(i)];
        if (lvl_wr_taken[i])           lvl_q[i] <= wdata[pin_bit(i)];
      end
    end
  end

  assign pad_oe   = en_q & ~dir_q;
  assign pad_out  = lvl_q;
  assign lvl_view = en_q & ((dir_q & pad_s) | (~dir_q & lvl_q));

  always_comb begin
    rdata = '0;
    for (int i = 0; i < PINS; i++) begin
      if (byte_hit[i]) begin
        case (set_sel)
          SET_ENABLE: rdata[pin_bit(i)] = en_q[i];
          SET_DIR:    rdata[pin_bit(i)] = dir_q[i];
          SET_LEVEL:  rdata[pin_bit(i)] = lvl_view[i];
          default:    rdata[pin_bit(i)] = 1'b0;
        endcase
      end
    end
  end

  for (genvar g = 0; g < PINS; g++) begin : g_chk
    // R5: a level write to an input pin leaves the stored level untouched
    p_lvl_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_wr_blocked[g] |=> $stable(lvl_q[g]));
    // R6: a level write to an output pin lands and is what the pad drives
    p_lvl_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_wr_taken[g] |=> (pad_out[g] == $past(wdata[pin_bit(g)])));
    // R3: enable bit holds the written value
    p_en_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_set && byte_hit[g]) |=> (en_q[g] == $past(wdata[pin_bit(g)])));
    // R3: direction bit holds the written value
    p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_dir_set && byte_hit[g]) |=> (dir_q[g] == $past(wdata[pin_bit(g)])));
  end
endmodule

// File: rtl/dualbank_gpio_ctrl.sv
module dualbank_gpio_ctrl
  import dbgpio_pkg::*;
#(
  parameter int CORE_PINS          = 10,
  parameter int RESUME_PINS        = 4,
  parameter int CORE_ON_AT_RESET   = 7,
  parameter int RESUME_ON_AT_RESET = 3,
  localparam int TOTAL_PINS        = CORE_PINS + RESUME_PINS
) (
  input  logic                  clk,
  input  logic                  core_rst_n,
  input  logic                  resume_rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic                  bus_rd,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [TOTAL_PINS-1:0] pad_in,
  output logic [TOTAL_PINS-1:0] pad_out,
  output logic [TOTAL_PINS-1:0] pad_oe
);
  logic                  hit_resume;
  logic                  core_wr, resume_wr;
  logic [SET_W-1:0]      set_sel;
  logic [BYTE_SEL_W-1:0] byte_sel;
  logic [DATA_W-1:0]     core_rdata, resume_rdata;
  logic                  set_invalid;

  assign hit_resume  = bank_of(bus_addr);
  assign set_sel     = set_of(bus_addr);
  assign byte_sel    = byte_of(bus_addr);
  assign core_wr     = bus_wr && !hit_resume;
  assign resume_wr   = bus_wr && hit_resume;
  assign set_invalid = (set_sel > SET_LEVEL);

  gpio_bank #(.PINS(CORE_PINS), .RESET_ON(CORE_ON_AT_RESET)) u_core (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr      (core_wr),
    .set_sel (set_sel),
    .byte_sel(byte_sel),
    .wdata   (bus_wdata),
    .pad_in  (pad_in[CORE_PINS-1:0]),
    .pad_out (pad_out[CORE_PINS-1:0]),
    .pad_oe  (pad_oe[CORE_PINS-1:0]),
    .rdata   (core_rdata)
  );

  gpio_bank #(.PINS(RESUME_PINS), .RESET_ON(RESUME_ON_AT_RESET)) u_resume (
    .clk     (clk),
    .rst_n   (resume_rst_n),
    .wr      (resume_wr),
    .set_sel (set_sel),
    .byte_sel(byte_sel),
    .wdata   (bus_wdata),
    .pad_in  (pad_in[TOTAL_PINS-1:CORE_PINS]),
    .pad_out (pad_out[TOTAL_PINS-1:CORE_PINS]),
    .pad_oe  (pad_oe[TOTAL_PINS-1:CORE_PINS]),
    .rdata   (resume_rdata)
  );

  always_comb begin
    if (!bus_rd)         bus_rdata = '0;
    else if (hit_resume) bus_rdata = resume_rdata;
    else                 bus_rdata = core_rdata;
  end

  // R9: undecoded register sets read as zero
  p_invalid_set_zero_r9: assert property (@(posedge clk) disable iff (!core_rst_n || !resume_rst_n)
    (bus_rd && set_invalid) |-> (bus_rdata == '0));
  // R10: a core-bank write never disturbs the resume pads
  p_core_wr_isolated_r10: assert property (@(posedge clk) disable iff (!core_rst_n || !resume_rst_n)
    core_wr |=> ($stable(pad_oe[TOTAL_PINS-1:CORE_PINS]) && $stable(pad_out[TOTAL_PINS-1:CORE_PINS])));
endmodule

// File: tb/dualbank_gpio_ctrl_tb.sv
`timescale 1ns/1ps
module dualbank_gpio_ctrl_tb;
  localparam int NC = 10;
  localparam int NR = 4;
  localparam int NT = NC + NR;
  localparam int ONC = 7;
  localparam int ONR = 3;

  logic clk = 0;
  logic core_rst_n = 0, resume_rst_n = 0;
  logic [5:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [NT-1:0] pad_in = '0, pad_out, pad_oe;

  int checks = 0, failures = 0;
  bit m_en [NT], m_dir [NT], m_lvl [NT];

  always #4 clk = ~clk;

  dualbank_gpio_ctrl #(.CORE_PINS(NC), .RESUME_PINS(NR),
    .CORE_ON_AT_RESET(ONC), .RESUME_ON_AT_RESET(ONR)) u_dut (
    .clk(clk), .core_rst_n(core_rst_n), .resume_rst_n(resume_rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

  function automatic void model_reset(input int bank);
    int base = bank ? NC : 0;
    int cnt  = bank ? NR : NC;
    int on   = bank ? ONR : ONC;
    for (int p = 0; p < cnt; p++) begin
      m_en[base+p] = (p < on); m_dir[base+p] = 1; m_lvl[base+p] = 0;
    end
  endfunction

  // Register byte k holds pins 8k..8k+7; set 0 enable, 1 direction, 2 level.
  function automatic void model_write(input int a, input bit [7:0] d);
    int base = (a >= 32) ? NC : 0;
    int cnt  = (a >= 32) ? NR : NC;
    int kind = (a % 32) / 4;
    int bi   = a % 4;
    for (int b = 0; b < 8; b++) begin
      int p = bi * 8 + b;
      if (p < cnt) begin
        if (kind == 0) m_en[base+p] = d[b];
        else if (kind == 1) m_dir[base+p] = d[b];
        else if (kind == 2 && !m_dir[base+p]) m_lvl[base+p] = d[b];
      end
    end
  endfunction

  function automatic bit [7:0] exp_read(input int a);
    bit [7:0] r = 0;
    int base = (a >= 32) ? NC : 0;
    int cnt  = (a >= 32) ? NR : NC;
    int kind = (a % 32) / 4;
    int bi   = a % 4;
    for (int b = 0; b < 8; b++) begin
      int p = bi * 8 + b;
      if (p < cnt) begin
        int g = base + p;
        if (kind == 0) r[b] = m_en[g];
        else if (kind == 1) r[b] = m_dir[g];
        else if (kind == 2) r[b] = m_en[g] ? (m_dir[g] ? pad_in[g] : m_lvl[g]) : 1'b0;
      end
    end
    return r;
  endfunction

  task automatic do_write(input int a, input bit [7:0] d);
    @(negedge clk);
    bus_addr = 6'(a); bus_wdata = d; bus_wr = 1;
    @(posedge clk);
    model_write(a, d);
    #1 bus_wr = 0;
  endtask

  task automatic check_read(input int a, input string tag);
    bit [7:0] e;
    @(negedge clk);
    bus_addr = 6'(a); bus_rd = 1;
    #1;
    e = exp_read(a);
    checks++;
    if (bus_rdata !== e) begin
      failures++;
      $display("FAIL %s read addr 0x%02h actual 0x%02h expected 0x%02h", tag, a, bus_rdata, e);
    end
    bus_rd = 0;
  endtask

  task automatic check_pads(input string tag);
    bit [NT-1:0] eoe, eout;
    @(negedge clk);
    for (int g = 0; g < NT; g++) begin
      eoe[g] = m_en[g] & ~m_dir[g];
      eout[g] = m_lvl[g];
    end
    checks++;
    if (pad_oe !== eoe || pad_out !== eout) begin
      failures++;
      $display("FAIL %s pads oe/out actual %b/%b expected %b/%b", tag, pad_oe, pad_out, eoe, eout);
    end
  endtask

  task automatic set_pads(input bit [NT-1:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (2) @(posedge clk);
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < 12; k++) begin
      check_read(k, tag);
      check_read(32 + k, tag);
    end
    check_pads(tag);
  endtask

  task automatic check_bit(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset(0); model_reset(1);
    repeat (3) @(posedge clk);
    @(negedge clk); core_rst_n = 1; resume_rst_n = 1;

    // R2 R8: reset values and no driven pads
    check_all("R2");

    // R1 R3: enable pins 7..9 and resume pin 3
    do_write(8'h00, 8'hFF);
    do_write(8'h01, 8'h03);
    do_write(8'h20, 8'h0F);
    check_all("R1");

    // R4 R5: pin 2 is input, a level write is ignored
    set_pads('0);
    do_write(8'h08, 8'h04);
    check_read(8'h08, "R5");
    check_pads("R5");
    // R4 R6: pin 3 output, level 1, back to input, then output again
    do_write(8'h04, 8'hF7);
    do_write(8'h08, 8'h08);
    check_pads("R4");
    do_write(8'h04, 8'hFF);
    check_pads("R6");
    do_write(8'h04, 8'hF7);
    check_pads("R6");
    check_read(8'h08, "R6");

    // R7: synchronizer latency on pin 2
    @(negedge clk); pad_in[2] = 1;
    @(posedge clk);
    @(negedge clk); bus_addr = 6'h08; bus_rd = 1; #1;
    check_bit("R7 one edge after pad change", bus_rdata[2], 1'b0);
    bus_rd = 0;
    @(posedge clk);
    @(negedge clk); bus_addr = 6'h08; bus_rd = 1; #1;
    check_bit("R7 two edges after pad change", bus_rdata[2], 1'b1);
    bus_rd = 0;

    // R8: disable pin 3 while output
    do_write(8'h00, 8'hF7);
    check_pads("R8");
    check_read(8'h08, "R8");

    // R9: unused addresses and bits
    do_write(8'h0C, 8'hFF);
    do_write(8'h1F, 8'hFF);
    do_write(8'h02, 8'hFF);
    do_write(8'h30, 8'hFF);
    check_all("R9");
    check_read(8'h0C, "R9");
    check_read(8'h3D, "R9");
    @(negedge clk); bus_addr = 6'h00; bus_rd = 0; #1;
    check_bit("R9 read data idle", bus_rdata == 8'h00, 1'b1);

    // R10: reset only the resume bank
    do_write(8'h24, 8'h00);
    do_write(8'h28, 8'h05);
    @(negedge clk); resume_rst_n = 0;
    model_reset(1);
    @(negedge clk); resume_rst_n = 1;
    check_all("R10");

    // Random mix: R1 R3 R4 R5 R7 R9
    void'($urandom(32'h5eed));
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 6) begin
        int a = $urandom_range(0, 11) + ($urandom_range(0, 1) ? 32 : 0);
        if ($urandom_range(0, 7) == 0) a = $urandom_range(0, 63);
        do_write(a, 8'($urandom));
      end else if (op < 7) begin
        set_pads(NT'($urandom));
      end else begin
        check_read($urandom_range(0, 63), "R3 random");
      end
      if (it % 16 == 0) check_pads("R4 random");
    end
    check_all("R7 random final");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule